// File: doc/BRIEF.md
# Dual Power-Good Monitor with Shared Delay

This block produces one power-good indicator for each of two regulator channels. Each channel supplies two digital comparator flags. The first says the feedback level is below the fault threshold, which is about 93% of the regulated level on a falling output. The second says the level is back above the recovery threshold, which sits about 2% higher. The gap between the two thresholds is the hysteresis band. The indicator of a good channel drops only after the fault flag has held for the full delay, so short dips are filtered out. The indicator of a faulted channel rises only after the recovery flag has held for the same delay. When the feedback sits inside the hysteresis band, the indicator keeps its value.

One delay setting serves both channels. It comes from a programmable count, or from a short fixed default (about 20 µs at the default clock) when no count is selected. Each channel keeps its own qualification counter, loaded against the shared setting, so events that overlap on the two channels are each timed from their own start. Clearing a channel's enable pulls its indicator low in the same cycle. After re-enable, or after reset, the channel must qualify again through a full delay before its indicator can rise.

A high `pg_good` bit means the channel is good. A pad stage turns a low bit into the pulled-down open-drain state.

Top module: `pg_dual_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every `pg_good` bit is 0.
- R2: An enabled channel whose indicator is low raises it on the clock edge that ends D consecutive sampled cycles with `fb_above_recover`=1 and `fb_below_fault`=0. A break in that run restarts the count.
- R3: An enabled channel whose indicator is high lowers it on the clock edge that ends D consecutive sampled cycles with `fb_below_fault`=1. A fault run shorter than D leaves the indicator high.
- R4: A cycle with both flags at 0 (inside the hysteresis band) keeps the indicator unchanged and discards any partial count.
- R5: The delay D is the shared default `DEF_DELAY` when `dly_use_cfg`=0. When `dly_use_cfg`=1, D is `dly_cfg_count`, with a count of 0 treated as 1.
- R6: `chan_en[i]`=0 forces `pg_good[i]` to 0 combinationally in the same cycle. After re-enable the channel must requalify as in R2.
- R7: The two channels are timed independently. Bit i of each input vector and of `pg_good` belongs to channel i, and an event on one channel neither starts, stops nor shifts the count of the other.
- R8: A cycle with both flags at 1 counts as a fault. It advances a good channel toward falling and never lets a low channel recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Per-channel enable |
| fb_below_fault | input | NCH | Feedback below the fault threshold |
| fb_above_recover | input | NCH | Feedback above the recovery threshold |
| dly_use_cfg | input | 1 | 1: use programmed delay, 0: use default |
| dly_cfg_count | input | CNT_W | Programmed delay in clock cycles |
| pg_good | output | NCH | Per-channel power-good, 1 = good |

## Verification
The bench builds the block with CNT_W=4 and DEF_DELAY=3. At these sizes it can sweep every programmed count from 0 to 7, plus the default, within a short run. That reaches the 0-to-1 clamp, the one-cycle delay in which a qualifying run is a single sample, and runs that stop exactly one cycle short of the limit. For every delay it overlaps recovery on one channel with a fault glitch on the other. It also applies both flags at once and toggles the enable in the middle of a count.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

  typedef enum logic {
    PG_LOW  = 1'b0,
    PG_HIGH = 1'b1
  } pg_state_e;

endpackage

// File: rtl/pg_delay_sel.sv
module pg_delay_sel #(
  parameter int CNT_W     = 12,
  parameter int DEF_DELAY = 2000
) (
  input  logic             use_cfg,
  input  logic [CNT_W-1:0] cfg_count,
  output logic [CNT_W-1:0] delay_eff
);

  localparam logic [CNT_W-1:0] DEF_W = CNT_W'(DEF_DELAY);

  // Effective delay in cycles; never below one.
  function automatic logic [CNT_W-1:0] eff_delay(
    input logic             sel,
    input logic [CNT_W-1:0] prog,
    input logic [CNT_W-1:0] dflt
  );
    logic [CNT_W-1:0] pick;
    pick = sel ? prog : dflt;
    if (pick == '0) pick = CNT_W'(1);
    return pick;
  endfunction

  assign delay_eff = eff_delay(use_cfg, cfg_count, DEF_W);

endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pgmon_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             below,
  input  logic             above,
  input  logic [CNT_W-1:0] delay,
  output logic             pg,
  output logic             ev_rise,
  output logic             ev_fall
);

  pg_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             toward;
  logic             done;

  // True when this sample completes a run of 'dly' qualifying cycles.
  function automatic logic run_complete(
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] dly
  );
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, dly};
  endfunction

  always_comb begin
    if (state_q == PG_HIGH) toward = below;
    else                    toward = above & ~below;
    done    = toward & run_complete(cnt_q, delay);
    ev_rise = en & done & (state_q == PG_LOW);
    ev_fall = en & done & (state_q == PG_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_LOW;
      cnt_q   <= '0;
    end else if (!en) begin
      state_q <= PG_LOW;
      cnt_q   <= '0;
    end else if (!toward) begin
      cnt_q   <= '0;
    end else if (done) begin
      state_q <= (state_q == PG_HIGH) ? PG_LOW : PG_HIGH;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign pg = en & (state_q == PG_HIGH);

endmodule

// File: rtl/pg_dual_monitor.sv
module pg_dual_monitor #(
  parameter int NCH       = 2,
  parameter int CNT_W     = 12,
  parameter int DEF_DELAY = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   chan_en,
  input  logic [NCH-1:0]   fb_below_fault,
  input  logic [NCH-1:0]   fb_above_recover,
  input  logic             dly_use_cfg,
  input  logic [CNT_W-1:0] dly_cfg_count,
  output logic [NCH-1:0]   pg_good
);

  logic [CNT_W-1:0] delay_eff;
  logic [NCH-1:0]   ev_rise;
  logic [NCH-1:0]   ev_fall;

  pg_delay_sel #(
    .CNT_W     (CNT_W),
    .DEF_DELAY (DEF_DELAY)
  ) u_dsel (
    .use_cfg   (dly_use_cfg),
    .cfg_count (dly_cfg_count),
    .delay_eff (delay_eff)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pg_channel #(
      .CNT_W (CNT_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (chan_en[i]),
      .below   (fb_below_fault[i]),
      .above   (fb_above_recover[i]),
      .delay   (delay_eff),
      .pg      (pg_good[i]),
      .ev_rise (ev_rise[i]),
      .ev_fall (ev_fall[i])
    );
  end

endmodule

// File: rtl/pg_dual_monitor_chk.sv
module pg_dual_monitor_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] fb_below_fault,
  input logic [NCH-1:0] fb_above_recover,
  input logic [NCH-1:0] pg_good,
  input logic [NCH-1:0] ev_rise,
  input logic [NCH-1:0] ev_fall
);

  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (pg_good == '0);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_rise_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_good[i]) |-> $past(chan_en[i] & fb_above_recover[i] & ~fb_below_fault[i]));

    p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pg_good[i]) |-> (!chan_en[i] || $past(fb_below_fault[i])));

    p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chan_en[i] & ~fb_below_fault[i] & ~fb_above_recover[i]) && chan_en[i])
        |-> $stable(pg_good[i]));

    p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |-> !pg_good[i]);

    p_event_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rise[i] |=> (pg_good[i] || !chan_en[i]));

    p_both_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_good[i]) |-> !$past(fb_below_fault[i]));
  end

endmodule

bind pg_dual_monitor pg_dual_monitor_chk #(.NCH(NCH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .chan_en          (chan_en),
  .fb_below_fault   (fb_below_fault),
  .fb_above_recover (fb_above_recover),
  .pg_good          (pg_good),
  .ev_rise          (ev_rise),
  .ev_fall          (ev_fall)
);

// File: tb/pg_dual_monitor_test.sv
`timescale 1ns/1ps
module pg_dual_monitor_test;

  localparam int NCH = 2;
  localparam int CW  = 4;
  localparam int DEF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] en = '0, below = '0, above = '0;
  logic          dsel = 1'b0;
  logic [CW-1:0] dcfg = '0;
  logic [NCH-1:0] pg;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pg_dual_monitor #(.NCH(NCH), .CNT_W(CW), .DEF_DELAY(DEF)) uut (
    .clk (clk), .rst_n (rst_n), .chan_en (en),
    .fb_below_fault (below), .fb_above_recover (above),
    .dly_use_cfg (dsel), .dly_cfg_count (dcfg), .pg_good (pg)
  );

  function automatic int want_delay(input logic s, input int c);
    if (s == 1'b0) return DEF;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    en = 2'b11; above = 2'b11;
    step(3);
    chk("R1 in reset", pg, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 first cycle after release", pg, 0);
    step(DEF - 2);
    chk("R2/R5 default not yet", pg, 0);
    step(1);
    chk("R2/R5 default rise", pg, 3);

    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        int d;
        d = want_delay(s[0], c);
        en = 2'b00; below = 2'b00; above = 2'b00;
        #1 chk("R6 disable immediate", pg, 0);
        step(1);
        dsel = s[0]; dcfg = CW'(c);
        en = 2'b11; above = 2'b01;
        step(d - 1);
        chk("R2 before limit", pg, 0);
        step(1);
        chk("R2/R5 rise ch0, R4 ch1 held low", pg, 1);

        // ch1 starts recovering while ch0 sees a short fault
        above = 2'b10; below = 2'b01;
        step(d - 1);
        chk("R3 short glitch ignored", pg[0], 1);
        below = 2'b00;
        step(1);
        chk("R7 ch1 rises on own count", pg, 3);

        // real fault on ch0 only
        below = 2'b01;
        step(d - 1);
        chk("R3 before limit", pg[0], 1);
        step(1);
        chk("R3 fall after full run", pg[0], 0);
        chk("R7 ch1 unaffected", pg[1], 1);

        // both flags at once on both channels
        below = 2'b11; above = 2'b11;
        step(d);
        chk("R8 both flags fault ch1", pg[1], 0);
        step(2);
        chk("R8 both flags block recovery ch0", pg[0], 0);

        // broken recovery run on ch0
        below = 2'b00; above = 2'b01;
        step(d - 1);
        above = 2'b00;
        step(1);
        chk("R4 band discards count", pg[0], 0);
        above = 2'b01;
        step(d - 1);
        chk("R2 restart not yet", pg[0], 0);
        step(1);
        chk("R2 restart rise", pg[0], 1);

        // re-enable must requalify
        en = 2'b10;
        step(1);
        chk("R6 off low", pg[0], 0);
        en = 2'b11;
        step(d - 1);
        chk("R6 requalify not yet", pg[0], 0);
        step(1);
        chk("R6 requalify rise", pg[0], 1);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule